// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block turns four power-control bits into enables for the processor core, the main clock, the sub-main clock, the auxiliary clock, the DCO DC generator and the crystal oscillator. The bits pick one active mode and five low-power modes. Any combination outside that set is decoded bit by bit, with each bit gating only its own clocks. The enables are registered outputs and model the control side of real gating cells.

Software writes the bits through a write strobe. When the core accepts an interrupt, the controller saves the current bits in a save store and clears the live bits, so the handler runs in active mode. A return strobe puts the saved bits back, and the device drops into its previous low-power mode again. The save store is one entry deep by default. A parameter makes it a deeper last-in first-out store for nested handlers.

A separate input reports whether the DCO is the active-mode clock source. The controller uses it to decide whether the DC generator may be switched off while the sub-main clock keeps running.

Top module: `lpm_clkgate_ctrl`

## Requirements
- R1: After reset every enable output is 1 and `mode_code` is 0, meaning active mode.
- R2: Bits of `mode_wdata` are [0] core off, [1] generator control 0, [2] generator control 1, [3] oscillator off. `cpu_en` and `mclk_en` equal NOT bit 0. `smclk_en` equals NOT bit 2. `aclk_en` and `xosc_en` equal NOT bit 3.
- R3: `dcogen_en` is 1 when bit 1 is 0. When bit 1 is 1, it stays 1 only if `dco_active_src` is 1 and at least one of bit 0 and bit 2 is 0. Otherwise it is 0.
- R4: `mode_code` decodes the bits {3,2,1,0} as follows: 0000→0 (active), 0001→1 (mode 0), 0011→2 (mode 1), 0101→3 (mode 2), 0111→4 (mode 3), 1111→5 (mode 4). Every other pattern gives 7.
- R5: Suppose a strobe is presented in the cycle before a rising edge. The outputs take the new value at that edge and stay unchanged on edges with no strobe, as long as `dco_active_src` is steady.
- R6: At the edge where `irq_accept` is high, the live bits are saved and cleared. All enables become 1 and `mode_code` becomes 0.
- R7: At the edge where `reti` is high and `irq_accept` is low, the most recently saved bits become live again.
- R8: Suppose `mode_wr` and `irq_accept` are high in the same cycle. The written bits are the ones saved, the live mode is active, and a later `reti` restores the written bits.
- R9: Suppose `irq_accept` and `reti` are high in the same cycle. The live mode stays active, the save store is unchanged, and a later `reti` restores the bits saved before.
- R10: Suppose `mode_wr` and `reti` are high in the same cycle and `irq_accept` is low. The write is dropped and the restored bits become live.
- R11: A `reti` takes the entry it restores out of the save store and leaves zeros behind. A `reti` with nothing saved therefore yields active mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Write strobe for the power-control bits |
| mode_wdata | input | 4 | Power-control bits to write |
| irq_accept | input | 1 | Interrupt accepted: save the bits and enter active mode |
| reti | input | 1 | Return from interrupt: restore the saved bits |
| dco_active_src | input | 1 | DCO is the active-mode clock source |
| cpu_en | output | 1 | Core enable |
| mclk_en | output | 1 | Main clock enable |
| smclk_en | output | 1 | Sub-main clock enable |
| aclk_en | output | 1 | Auxiliary clock enable |
| dcogen_en | output | 1 | DCO DC generator enable |
| xosc_en | output | 1 | Crystal oscillator enable |
| mode_code | output | 3 | Current mode code |

## Verification
The strobes that can coincide are a software write and an interrupt accept, an accept and a return, and a write and a return. The bench provokes each pair by asserting both strobes in one cycle from a known low-power mode. It judges the result in two steps. First it checks the outputs one edge later: active mode is expected, except that a write paired with a return gives the restored mode. Then it issues a separate return and checks which mode comes back.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   localparam int MODE_W  = 4;
   localparam int B_CPUOFF = 0;
   localparam int B_GEN0   = 1;
   localparam int B_GEN1   = 2;
   localparam int B_OSCOFF = 3;
   localparam int CODE_W  = 3;

   typedef logic [MODE_W-1:0] mode_bits_t;

   typedef enum logic [CODE_W-1:0] {
      MC_ACTIVE = 3'd0,
      MC_LP0    = 3'd1,
      MC_LP1    = 3'd2,
      MC_LP2    = 3'd3,
      MC_LP3    = 3'd4,
      MC_LP4    = 3'd5,
      MC_OTHER  = 3'd7
   } mode_code_t;

   typedef struct packed {
      logic cpu;
      logic mclk;
      logic smclk;
      logic aclk;
      logic dcogen;
      logic xosc;
   } gates_t;

   localparam gates_t GATES_ALL_ON = '{cpu: 1'b1, mclk: 1'b1, smclk: 1'b1,
                                       aclk: 1'b1, dcogen: 1'b1, xosc: 1'b1};
endpackage

// File: rtl/lpm_mode_store.sv
module lpm_mode_store
   import lpm_pkg::*;
#(
   parameter int NEST_DEPTH = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  mode_bits_t wr_bits,
   input  logic       irq_take,
   input  logic       irq_ret,
   output mode_bits_t bits_nxt,
   output mode_bits_t bits_q
);
   localparam int SAVE_BITS = NEST_DEPTH * MODE_W;

   initial begin
      assert (NEST_DEPTH >= 1)
         else $error("lpm_mode_store: NEST_DEPTH must be at least 1");
   end

   mode_bits_t top_q;
   logic       do_push;
   logic       do_pop;
   mode_bits_t push_val;

   assign do_push  = irq_take & ~irq_ret;
   assign do_pop   = irq_ret & ~irq_take;
   assign push_val = wr_en ? wr_bits : bits_q;

   always_comb begin
      if (irq_take)     bits_nxt = '0;
      else if (irq_ret) bits_nxt = top_q;
      else if (wr_en)   bits_nxt = wr_bits;
      else              bits_nxt = bits_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits_q <= '0;
      else        bits_q <= bits_nxt;
   end

   generate
      if (NEST_DEPTH == 1) begin : g_single
         mode_bits_t save_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       save_q <= '0;
            else if (do_push) save_q <= push_val;
            else if (do_pop)  save_q <= '0;
         end
         assign top_q = save_q;
      end else begin : g_stack
         logic [SAVE_BITS-1:0] stk_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       stk_q <= '0;
            else if (do_push) stk_q <= {stk_q[SAVE_BITS-MODE_W-1:0], push_val};
            else if (do_pop)  stk_q <= {{MODE_W{1'b0}}, stk_q[SAVE_BITS-1:MODE_W]};
         end
         assign top_q = stk_q[MODE_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/lpm_decode.sv
module lpm_decode
   import lpm_pkg::*;
(
   input  mode_bits_t bits,
   input  logic       dco_used,
   output gates_t     gates,
   output mode_code_t code
);
   logic cpuoff, gen0, gen1, oscoff;

   assign cpuoff = bits[B_CPUOFF];
   assign gen0   = bits[B_GEN0];
   assign gen1   = bits[B_GEN1];
   assign oscoff = bits[B_OSCOFF];

   always_comb begin
      gates.cpu    = ~cpuoff;
      gates.mclk   = ~cpuoff;
      gates.smclk  = ~gen1;
      gates.aclk   = ~oscoff;
      gates.xosc   = ~oscoff;
      gates.dcogen = ~gen0 | (dco_used & (~cpuoff | ~gen1));
   end

   always_comb begin
      unique case (bits)
         4'b0000: code = MC_ACTIVE;
         4'b0001: code = MC_LP0;
         4'b0011: code = MC_LP1;
         4'b0101: code = MC_LP2;
         4'b0111: code = MC_LP3;
         4'b1111: code = MC_LP4;
         default: code = MC_OTHER;
      endcase
   end
endmodule

// File: rtl/lpm_gate_reg.sv
module lpm_gate_reg
   import lpm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  gates_t     gates_d,
   input  mode_code_t code_d,
   output gates_t     gates_q,
   output mode_code_t code_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gates_q <= GATES_ALL_ON;
         code_q  <= MC_ACTIVE;
      end else begin
         gates_q <= gates_d;
         code_q  <= code_d;
      end
   end
endmodule

// File: rtl/lpm_clkgate_ctrl.sv
module lpm_clkgate_ctrl
   import lpm_pkg::*;
#(
   parameter int NEST_DEPTH = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_wr,
   input  logic [3:0] mode_wdata,
   input  logic       irq_accept,
   input  logic       reti,
   input  logic       dco_active_src,
   output logic       cpu_en,
   output logic       mclk_en,
   output logic       smclk_en,
   output logic       aclk_en,
   output logic       dcogen_en,
   output logic       xosc_en,
   output logic [2:0] mode_code
);
   mode_bits_t bits_nxt;
   mode_bits_t bits_q;
   gates_t     gates_d, gates_q;
   mode_code_t code_d, code_q;

   lpm_mode_store #(.NEST_DEPTH(NEST_DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (mode_wr),
      .wr_bits  (mode_wdata),
      .irq_take (irq_accept),
      .irq_ret  (reti),
      .bits_nxt (bits_nxt),
      .bits_q   (bits_q)
   );

   lpm_decode u_dec (
      .bits     (bits_nxt),
      .dco_used (dco_active_src),
      .gates    (gates_d),
      .code     (code_d)
   );

   lpm_gate_reg u_greg (
      .clk     (clk),
      .rst_n   (rst_n),
      .gates_d (gates_d),
      .code_d  (code_d),
      .gates_q (gates_q),
      .code_q  (code_q)
   );

   logic unused_bits;
   assign unused_bits = ^bits_q;

   assign cpu_en    = gates_q.cpu;
   assign mclk_en   = gates_q.mclk;
   assign smclk_en  = gates_q.smclk;
   assign aclk_en   = gates_q.aclk;
   assign dcogen_en = gates_q.dcogen;
   assign xosc_en   = gates_q.xosc;
   assign mode_code = code_q;
endmodule

// File: rtl/lpm_clkgate_chk.sv
module lpm_clkgate_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mode_wr,
   input logic [3:0] mode_wdata,
   input logic       irq_accept,
   input logic       reti,
   input logic       dco_active_src,
   input logic       cpu_en,
   input logic       mclk_en,
   input logic       smclk_en,
   input logic       aclk_en,
   input logic       dcogen_en,
   input logic       xosc_en,
   input logic [2:0] mode_code
);
   // R2
   core_clk_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mclk_en == cpu_en);

   // R2
   osc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xosc_en == aclk_en);

   // R4
   deepest_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'd5) |-> (!cpu_en && !smclk_en && !aclk_en && !dcogen_en && !xosc_en));

   // R5
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && !irq_accept && !reti) |=>
         (cpu_en == !$past(mode_wdata[0]) && smclk_en == !$past(mode_wdata[2])
          && aclk_en == !$past(mode_wdata[3])));

   // R5
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_wr && !irq_accept && !reti && $stable(dco_active_src)) |=>
         ($stable(cpu_en) && $stable(smclk_en) && $stable(aclk_en)
          && $stable(dcogen_en) && $stable(mode_code)));

   // R6
   wake_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_accept |=> (mode_code == 3'd0 && cpu_en && mclk_en && smclk_en
                      && aclk_en && dcogen_en && xosc_en));
endmodule

bind lpm_clkgate_ctrl lpm_clkgate_chk u_lpm_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .mode_wr        (mode_wr),
   .mode_wdata     (mode_wdata),
   .irq_accept     (irq_accept),
   .reti           (reti),
   .dco_active_src (dco_active_src),
   .cpu_en         (cpu_en),
   .mclk_en        (mclk_en),
   .smclk_en       (smclk_en),
   .aclk_en        (aclk_en),
   .dcogen_en      (dcogen_en),
   .xosc_en        (xosc_en),
   .mode_code      (mode_code)
);

// File: tb/lpm_clkgate_ctrl_bench.sv
module lpm_clkgate_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_wr = 1'b0;
   logic [3:0] mode_wdata = 4'd0;
   logic       irq_accept = 1'b0;
   logic       reti = 1'b0;
   logic       dco_active_src = 1'b0;
   logic       cpu_en, mclk_en, smclk_en, aclk_en, dcogen_en, xosc_en;
   logic [2:0] mode_code;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lpm_clkgate_ctrl u_lpm_clkgate_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .irq_accept(irq_accept), .reti(reti), .dco_active_src(dco_active_src),
      .cpu_en(cpu_en), .mclk_en(mclk_en), .smclk_en(smclk_en), .aclk_en(aclk_en),
      .dcogen_en(dcogen_en), .xosc_en(xosc_en), .mode_code(mode_code)
   );

   // packed expectation: {cpu, mclk, smclk, aclk, dcogen, xosc, code[2:0]}
   function automatic logic [8:0] model(input logic [3:0] b, input logic dco);
      logic [2:0] c;
      logic g;
      case (b)
         4'b0000: c = 3'd0;
         4'b0001: c = 3'd1;
         4'b0011: c = 3'd2;
         4'b0101: c = 3'd3;
         4'b0111: c = 3'd4;
         4'b1111: c = 3'd5;
         default: c = 3'd7;
      endcase
      g = !b[1] || (dco && (!b[0] || !b[2]));
      return {!b[0], !b[0], !b[2], !b[3], g, !b[3], c};
   endfunction

   function automatic logic [8:0] observed();
      return {cpu_en, mclk_en, smclk_en, aclk_en, dcogen_en, xosc_en, mode_code};
   endfunction

   task automatic check(input string req, input logic [8:0] exp);
      checks++;
      if (observed() !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, observed(), exp);
      end
   endtask

   // present strobes for one cycle, outputs sampled at the next falling edge
   task automatic pulse(input logic wr, input logic [3:0] d, input logic irq, input logic ret);
      @(negedge clk);
      mode_wr = wr; mode_wdata = d; irq_accept = irq; reti = ret;
      @(negedge clk);
      mode_wr = 1'b0; irq_accept = 1'b0; reti = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", model(4'b0000, 1'b0));
      rst_n = 1'b1;

      // R2 R3 R4 R5: sweep of every bit pattern with both source settings
      for (int dco = 0; dco < 2; dco++) begin
         for (int p = 0; p < 16; p++) begin
            dco_active_src = dco[0];
            pulse(1'b1, p[3:0], 1'b0, 1'b0);
            check("R2/R3/R4/R5", model(p[3:0], dco[0]));
            @(negedge clk);
            check("R5 hold", model(p[3:0], dco[0]));
         end
      end
      dco_active_src = 1'b1;

      // R6 and R7
      pulse(1'b1, 4'b0111, 1'b0, 1'b0);
      check("R4 mode3", model(4'b0111, 1'b1));
      pulse(1'b0, 4'b0000, 1'b1, 1'b0);
      check("R6 wake", model(4'b0000, 1'b1));
      pulse(1'b0, 4'b0000, 1'b0, 1'b1);
      check("R7 restore", model(4'b0111, 1'b1));
      // R11: second return with nothing saved
      pulse(1'b0, 4'b0000, 1'b0, 1'b1);
      check("R11 empty return", model(4'b0000, 1'b1));

      // R8: write and accept together
      pulse(1'b1, 4'b1111, 1'b1, 1'b0);
      check("R8 active", model(4'b0000, 1'b1));
      pulse(1'b0, 4'b0000, 1'b0, 1'b1);
      check("R8 restore written", model(4'b1111, 1'b1));

      // R9: accept and return together
      pulse(1'b1, 4'b0001, 1'b0, 1'b0);
      pulse(1'b0, 4'b0000, 1'b1, 1'b0);
      check("R9 wake", model(4'b0000, 1'b1));
      pulse(1'b0, 4'b0000, 1'b1, 1'b1);
      check("R9 stays active", model(4'b0000, 1'b1));
      pulse(1'b0, 4'b0000, 1'b0, 1'b1);
      check("R9 restore kept", model(4'b0001, 1'b1));

      // R10: write and return together
      pulse(1'b1, 4'b0101, 1'b0, 1'b0);
      pulse(1'b0, 4'b0000, 1'b1, 1'b0);
      pulse(1'b1, 4'b1111, 1'b0, 1'b1);
      check("R10 write dropped", model(4'b0101, 1'b1));

      // R3: generator follows source flag change without a strobe
      pulse(1'b1, 4'b0011, 1'b0, 1'b0);
      check("R3 mode1 dco used", model(4'b0011, 1'b1));
      @(negedge clk); dco_active_src = 1'b0;
      @(negedge clk);
      check("R3 mode1 dco unused", model(4'b0011, 1'b0));

      done = 1'b1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule